// File: doc/BRIEF.md
# Selectable Strobe-Source Rate Divider

This block derives a slower enable strobe from one of four incoming enable strobes, all in a single system clock domain. A 32-bit configuration register holds a 2-bit source select, a 5-bit pre-divider and a 2-bit post-divider. The pre-divider sits only in the path of one designated source (source 3 by default). The common post-divider follows the source mux. The result is a registered single-cycle output strobe.

Software programs the register through a byte-strobed write port. A write can therefore change the divider fields without touching the source select. Any change to a field value restarts both divider counters from zero, so the new ratio counts from a known point.

Top module: `strobe_source_divider`

## Requirements
- R1: A synchronous active-high reset clears the register, so `rd_data` reads 0 (source 0, divide by 1), and it holds `out_tick` low.
- R2: The select field, register bits [17:16], chooses which bit of `src_tick` is counted. Strobes on the other three source bits have no effect on `out_tick`.
- R3: The post-divider field, bits [5:4], sets a ratio of field+1 (1 to 4). With the pre-divider bypassed, `out_tick` pulses on every (post+1)-th selected strobe.
- R4: The pre-divider field, bits [12:8], sets a ratio of field+1 (1 to 32). When select equals 3, it is cascaded ahead of the post-divider, so `out_tick` pulses once every (pre+1)*(post+1) selected strobes.
- R5: For select values 0, 1 and 2 the pre-divider field is ignored and the ratio is post+1 alone.
- R6: `wr_strb[0]` enables writing bits [7:0], `wr_strb[1]` bits [15:8], `wr_strb[2]` bits [23:16], and `wr_strb[3]` enables nothing writable. A field whose byte strobe is low keeps its value.
- R7: `rd_data` returns the current select, pre-divider and post-divider fields at their bit positions. All other bits read as zero.
- R8: A write that changes any field value clears both divider counters. A selected strobe in that write cycle is not counted, and the next pulse comes after a full count at the new ratio.
- R9: `out_tick` is registered. It is high for one cycle, in the cycle after the clock edge at which the selected strobe completes a count. It is never high after a cycle with no selected strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_strb | input | 4 | Byte write strobes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| src_tick | input | 4 | Source enable strobes, one per source |
| out_tick | output | 1 | Divided output strobe |

## Verification
`rd_data` comes from the register flops, so a write is visible right after the clock edge that captures it. `out_tick` is due exactly one edge after the edge that samples the strobe completing a count. The bench drives each write or strobe at a falling edge for one cycle and samples both outputs at the next falling edge. Each strobe is therefore checked against a count of selected strobes since the last clearing write, modulo the expected total ratio.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  localparam int REG_W    = 32;
  localparam int SEL_LSB  = 16;
  localparam int SEL_W    = 2;
  localparam int PRE_LSB  = 8;
  localparam int PRE_W    = 5;
  localparam int POST_LSB = 4;
  localparam int POST_W   = 2;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } ssd_cfg_t;
endpackage

// File: rtl/ssd_cfg_reg.sv
module ssd_cfg_reg
  import ssd_pkg::*;
#(
  parameter int DATA_W = REG_W,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [DATA_W-1:0] wr_data,
  output ssd_cfg_t          cfg,
  output logic              cfg_changed,
  output logic [DATA_W-1:0] rd_data
);
  ssd_cfg_t cfg_nxt;

  always_comb begin
    cfg_nxt = cfg;
    if (wr_en && wr_strb[SEL_LSB/8])  cfg_nxt.sel  = wr_data[SEL_LSB  +: SEL_W];
    if (wr_en && wr_strb[PRE_LSB/8])  cfg_nxt.pre  = wr_data[PRE_LSB  +: PRE_W];
    if (wr_en && wr_strb[POST_LSB/8]) cfg_nxt.post = wr_data[POST_LSB +: POST_W];
  end

  assign cfg_changed = (cfg_nxt != cfg);

  always_ff @(posedge clk) begin
    if (rst) cfg <= '0;
    else     cfg <= cfg_nxt;
  end

  always_comb begin
    rd_data = '0;
    rd_data[SEL_LSB  +: SEL_W]  = cfg.sel;
    rd_data[PRE_LSB  +: PRE_W]  = cfg.pre;
    rd_data[POST_LSB +: POST_W] = cfg.post;
  end
endmodule

// File: rtl/ssd_src_mux.sv
module ssd_src_mux #(
  parameter int NUM_SRC = 4,
  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SW-1:0]      sel,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel == SW'(i)) tick = src_tick[i];
  end
endmodule

// File: rtl/ssd_tick_divider.sv
module ssd_tick_divider #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] ratio_m1,
  output logic         terminal
);
  logic [W-1:0] cnt;

  assign terminal = tick_in && (cnt == ratio_m1);

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (tick_in) cnt <= terminal ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/strobe_source_divider.sv
module strobe_source_divider
  import ssd_pkg::*;
#(
  parameter int PRE_SRC = 3,
  localparam int NUM_SRC = 1 << SEL_W,
  localparam int STRB_W  = REG_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [STRB_W-1:0]  wr_strb,
  input  logic [REG_W-1:0]   wr_data,
  output logic [REG_W-1:0]   rd_data,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               out_tick
);
  ssd_cfg_t cfg;
  logic     cfg_changed;
  logic     sel_tick;
  logic     pre_active;
  logic     pre_term;
  logic     post_in;
  logic     post_term;

  ssd_cfg_reg #(.DATA_W(REG_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .cfg(cfg), .cfg_changed(cfg_changed),
    .rd_data(rd_data)
  );

  ssd_src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .src_tick(src_tick), .sel(cfg.sel), .tick(sel_tick)
  );

  assign pre_active = (cfg.sel == SEL_W'(PRE_SRC));

  ssd_tick_divider #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(cfg_changed),
    .tick_in(sel_tick && pre_active), .ratio_m1(cfg.pre),
    .terminal(pre_term)
  );

  assign post_in = pre_active ? pre_term : sel_tick;

  ssd_tick_divider #(.W(POST_W)) u_post (
    .clk(clk), .rst(rst), .clr(cfg_changed),
    .tick_in(post_in), .ratio_m1(cfg.post),
    .terminal(post_term)
  );

  always_ff @(posedge clk) begin
    if (rst) out_tick <= 1'b0;
    else     out_tick <= post_term && !cfg_changed;
  end
endmodule

// File: rtl/ssd_checker.sv
module ssd_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [3:0]  wr_strb,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [3:0]  src_tick,
  input logic        out_tick
);
  localparam logic [31:0] FIELD_MASK = 32'h0003_1F30;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (rd_data == 32'h0 && !out_tick));

  assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && src_tick[rd_data[17:16]] == 1'b0) |=> !out_tick);

  assert_div1_every_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && rd_data[17:16] != 2'd3 && rd_data[5:4] == 2'd0
     && src_tick[rd_data[17:16]]) |=> out_tick);

  assert_sel_held_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_strb[2]) |=> $stable(rd_data[17:16]));

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~FIELD_MASK) == 32'h0);

  assert_no_strobe_no_out_R9: assert property (@(posedge clk) disable iff (rst)
    (src_tick == 4'h0) |=> !out_tick);
endmodule

bind strobe_source_divider ssd_checker u_ssd_checker (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
  .wr_data(wr_data), .rd_data(rd_data), .src_tick(src_tick),
  .out_tick(out_tick)
);

// File: tb/test_strobe_source_divider.sv
module test_strobe_source_divider;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  src_tick = '0;
  logic        out_tick;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_source_divider i_strobe_source_divider (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
    .wr_data(wr_data), .rd_data(rd_data), .src_tick(src_tick),
    .out_tick(out_tick)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; one write cycle, optional strobes alongside.
  task automatic cfg_write(input logic [3:0] strb, input logic [31:0] data,
                           input logic [3:0] ticks);
    wr_en = 1'b1; wr_strb = strb; wr_data = data; src_tick = ticks;
    @(negedge clk);
    wr_en = 1'b0; wr_strb = '0; src_tick = '0;
  endtask

  task automatic strobe(input logic [3:0] ticks, input logic exp, input string tag);
    src_tick = ticks;
    @(negedge clk);
    src_tick = '0;
    check(tag, {31'b0, out_tick}, {31'b0, exp});
  endtask

  task automatic run_ratio(input int src, input int n, input int ratio, input string tag);
    for (int k = 1; k <= n; k++) begin
      strobe(4'b1 << src, (k % ratio) == 0, tag);
      if (k % ratio == 0) strobe(4'h0, 1'b0, {tag, " R9 idle"});
    end
  endtask

  task automatic t_reset;
    check("R1 rd_data after reset", rd_data, 32'h0);
    check("R1 out_tick after reset", {31'b0, out_tick}, 32'h0);
    run_ratio(0, 3, 1, "R1 source 0 divide 1");
  endtask

  task automatic t_post_div;
    cfg_write(4'b0001, 32'h0000_0010, 4'h0);
    check("R3 rd_data post=1", rd_data, 32'h0000_0010);
    run_ratio(0, 6, 2, "R3 post ratio 2");
    cfg_write(4'b0001, 32'h0000_0030, 4'h0);
    run_ratio(0, 8, 4, "R3 post ratio 4");
  endtask

  task automatic t_select;
    cfg_write(4'b0100, 32'h0002_0000, 4'h0);
    check("R2 rd_data sel=2", rd_data, 32'h0002_0030);
    for (int k = 0; k < 6; k++) strobe(4'b1011, 1'b0, "R2 unselected ignored");
    run_ratio(2, 8, 4, "R2 source 2 post ratio 4");
  endtask

  task automatic t_pre_bypass;
    cfg_write(4'b0010, 32'h0000_0500, 4'h0);
    check("R5 rd_data pre=5", rd_data, 32'h0002_0530);
    run_ratio(2, 8, 4, "R5 pre ignored on sel 2");
  endtask

  task automatic t_pre_cascade;
    cfg_write(4'b0100, 32'h0003_0000, 4'h0);
    run_ratio(3, 48, 24, "R4 cascade 6x4");
    cfg_write(4'b0011, 32'h0000_1F30, 4'h0);
    check("R4 rd_data pre=31", rd_data, 32'h0003_1F30);
    run_ratio(3, 256, 128, "R4 cascade 32x4");
    cfg_write(4'b0011, 32'h0000_0000, 4'h0);
    run_ratio(3, 4, 1, "R4 cascade 1x1");
  endtask

  task automatic t_strobes;
    cfg_write(4'b1000, 32'hFFFF_FFFF, 4'h0);
    check("R6 top lane writes nothing", rd_data, 32'h0003_0000);
    cfg_write(4'b0000, 32'hFFFF_FFFF, 4'h0);
    check("R6 no strobe writes nothing", rd_data, 32'h0003_0000);
    cfg_write(4'b0100, 32'h0000_0000, 4'h0);
    cfg_write(4'b0001, 32'hFFFF_FFFF, 4'h0);
    check("R6 lane 0 keeps select", rd_data, 32'h0000_0030);
    cfg_write(4'b1111, 32'hFFFF_FFFF, 4'h0);
    check("R7 unused bits zero", rd_data, 32'h0003_1F30);
  endtask

  task automatic t_restart;
    cfg_write(4'b0011, 32'h0000_0300, 4'h0);
    run_ratio(3, 2, 4, "R8 partial count");
    cfg_write(4'b0001, 32'h0000_0010, 4'b1000);
    check("R8 no out in change cycle", {31'b0, out_tick}, 32'h0);
    run_ratio(3, 16, 8, "R8 fresh count at ratio 8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_post_div();
    t_select();
    t_pre_bypass();
    t_pre_cascade();
    t_strobes();
    t_restart();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule